// File: doc/BRIEF.md
# Data fault syndrome capture encoder

This block builds the 32-bit status word that describes the most recent data abort and keeps it. The memory system supplies a one-cycle abort strobe, a generic fault kind with a lookup level, a layout select and a handful of qualifiers: write-not-read, a flag for cache-maintenance or address-translation instruction origin, an external-abort class bit, an address-not-valid flag, a 2-bit asynchronous error type and a 4-bit domain. On the clock edge where the strobe is high, the block looks up the fault code for the selected layout and packs the word. It then holds the word until the next abort.

Two layouts share one word. The short layout carries a 5-bit code split across the word and also carries the domain. The long layout carries a 6-bit code in the low bits. Each qualifier bit is passed through only for the fault classes where it means something, and is zero for all others. A fault kind that has no code in the selected layout is stored as a reserved code, and the block raises `code_unsupported`.

The control is a two-state machine. `ST_EMPTY` is the reset state, where no word has been captured. The transition `capture_first` (strobe high) moves it to `ST_HELD`. In `ST_HELD` the transition `capture_again` (strobe high) overwrites the word, and `hold` (strobe low) keeps it. The only way back to `ST_EMPTY` is reset.

Top module: `dfsc_capture`

## Requirements
- R1: After reset `syndrome` is all zero, and both `code_unsupported` and `syndrome_valid` are 0.
- R2: `syndrome` and `code_unsupported` take new values only on a clock edge where `abort_valid` is 1, and the result is visible after that edge. While `abort_valid` is 0 they keep their values whatever the other inputs do. `syndrome_valid` goes to 1 after the first capture and stays at 1.
- R3: Bit 9 of the word is 1 when `layout_long` was 1 at capture and 0 otherwise. Bits 31:17 are always 0.
- R4: In the short layout the 5-bit code sits as follows: code bit 4 in word bit 10, code bits 3:0 in word bits 3:0. The `domain` input goes to word bits 7:4, and bit 8 is 0.
- R5: In the long layout the 6-bit code sits in word bits 5:0, and bits 10 and 8:6 are 0.
- R6: `fault_kind` encodings are: 0 alignment, 1 debug, 2 translation, 3 access flag, 4 permission, 5 domain, 6 address size, 7 synchronous external not on walk, 8 synchronous external on walk, 9 asynchronous error, 10 synchronous parity not on walk, 11 synchronous parity on walk, 12 asynchronous parity, 13 TLB conflict, 14 lockdown, 15 unsupported exclusive. The short codes are: alignment 00001, debug 00010, access flag L1 00011 and L2 00110, translation L1 00101 and L2 00111, domain L1 01001 and L2 01011, permission L1 01101 and L2 01111, external not on walk 01000, external walk L1 01100 and L2 01110, TLB conflict 10000, lockdown 10100, exclusive 10101, asynchronous error 10110, asynchronous parity 11000, parity not on walk 11001, parity walk L1 11100 and L2 11110.
- R7: The long codes are: address size at levels 0 to 3 is 0000 followed by the level; translation, access flag and permission at levels 1 to 3 are 0001, 0010 and 0011 followed by the level; external walk and parity walk at levels 1 to 3 are 0101 and 0111 followed by the level; external not on walk 010000; asynchronous error 010001; parity not on walk 011000; asynchronous parity 011001; alignment 100001; debug 100010; TLB conflict 110000; lockdown 110100; exclusive 110101.
- R8: Any kind and level pair not listed for the selected layout makes `code_unsupported` 1. That covers address size in the short layout, domain in the long layout, short levels 0 and 3, and long level 0 other than address size. The code is then stored as 11111 (short) or 111111 (long). All other captures make `code_unsupported` 0.
- R9: Word bit 16 equals `addr_invalid` only when the kind is 7. For every other kind it is 0.
- R10: Word bits 15:14 equal `err_type` only when the long layout is selected and the long code is 010001. Otherwise they are 0.
- R11: Word bit 13 equals `cm_origin`. Word bit 11 is 1 when `cm_origin` is 1, and equals `wnr` otherwise.
- R12: Word bit 12 equals `ext_class` only for the external kinds 7, 8, 9, 10, 11 and 12. For every other kind it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_valid | input | 1 | One-cycle strobe: capture this fault |
| layout_long | input | 1 | 1 selects the long layout, 0 the short layout |
| fault_kind | input | 4 | Generic fault kind (encoding in R6) |
| fault_level | input | 2 | Lookup level of the fault |
| wnr | input | 1 | Access was a write |
| cm_origin | input | 1 | Fault came from a cache-maintenance or address-translation instruction |
| ext_class | input | 1 | Class bit for external aborts |
| addr_invalid | input | 1 | Fault address is not valid |
| err_type | input | 2 | Error state after an asynchronous error |
| domain | input | 4 | Domain of the fault address (short layout only) |
| syndrome | output | 32 | Captured status word |
| code_unsupported | output | 1 | The captured kind has no code in its layout |
| syndrome_valid | output | 1 | At least one word has been captured since reset |

## Verification
The assertions assume that `abort_valid` and every fault input are settled at the clock edge, and that after reset only the strobe starts a change. Properties that compare the word with inputs one cycle earlier also assume the qualifiers are stable for the whole capture cycle. The bench drives all inputs on the falling edge and raises the strobe for exactly one cycle per fault. Between captures it changes the other inputs freely while the strobe is low, which exercises the hold property without going outside those assumptions.

// File: rtl/dfsc_pkg.sv
package dfsc_pkg;
    localparam int WORD_W   = 32;
    localparam int KIND_W   = 4;
    localparam int LEVEL_W  = 2;
    localparam int DOMAIN_W = 4;
    localparam int AET_W    = 2;
    localparam int SHORT_W  = 5;
    localparam int LONG_W   = 6;
    localparam int PREFIX_W = LONG_W - LEVEL_W;

    // word bit positions that software decodes
    localparam int POS_ADDR_BAD = 16;
    localparam int POS_AET_LO   = 14;
    localparam int POS_CM       = 13;
    localparam int POS_EXT      = 12;
    localparam int POS_WNR      = 11;
    localparam int POS_SHORT_HI = 10;
    localparam int POS_LAYOUT   = 9;
    localparam int POS_DOMAIN   = 4;

    localparam logic [SHORT_W-1:0] SHORT_RSVD = '1;
    localparam logic [LONG_W-1:0]  LONG_RSVD  = '1;
    localparam logic [LONG_W-1:0]  LONG_ASYNC = 6'b010001;

    typedef enum logic [KIND_W-1:0] {
        FK_ALIGN     = 4'd0,
        FK_DEBUG     = 4'd1,
        FK_XLATE     = 4'd2,
        FK_AFLAG     = 4'd3,
        FK_PERM      = 4'd4,
        FK_DOMAIN    = 4'd5,
        FK_ADDRSZ    = 4'd6,
        FK_EXT_SYNC  = 4'd7,
        FK_EXT_WALK  = 4'd8,
        FK_ASYNC_ERR = 4'd9,
        FK_PAR_SYNC  = 4'd10,
        FK_PAR_WALK  = 4'd11,
        FK_PAR_ASYNC = 4'd12,
        FK_TLB_CONF  = 4'd13,
        FK_LOCKDOWN  = 4'd14,
        FK_EXCL      = 4'd15
    } fault_kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } cap_state_e;

    typedef struct packed {
        fault_kind_e              kind;
        logic [LEVEL_W-1:0]       level;
        logic                     layout_long;
        logic                     wnr;
        logic                     cm_origin;
        logic                     ext_class;
        logic                     addr_invalid;
        logic [AET_W-1:0]         err_type;
        logic [DOMAIN_W-1:0]      domain;
    } fault_desc_t;
endpackage

// File: rtl/dfsc_short_enc.sv
module dfsc_short_enc
    import dfsc_pkg::*;
(
    input  fault_kind_e          kind,
    input  logic [LEVEL_W-1:0]   level,
    output logic [SHORT_W-1:0]   code,
    output logic                 ok
);
    // level-keyed kinds exist only at lookup levels 1 and 2
    function automatic logic [SHORT_W:0] by_level(input logic [LEVEL_W-1:0] lv,
                                                  input logic [SHORT_W-1:0] c1,
                                                  input logic [SHORT_W-1:0] c2);
        if (lv == LEVEL_W'(1)) return {1'b1, c1};
        if (lv == LEVEL_W'(2)) return {1'b1, c2};
        return {1'b0, SHORT_RSVD};
    endfunction

    logic [SHORT_W:0] pick;

    always_comb begin
        pick = {1'b0, SHORT_RSVD};
        unique case (kind)
            FK_ALIGN:     pick = {1'b1, 5'b00001};
            FK_DEBUG:     pick = {1'b1, 5'b00010};
            FK_XLATE:     pick = by_level(level, 5'b00101, 5'b00111);
            FK_AFLAG:     pick = by_level(level, 5'b00011, 5'b00110);
            FK_PERM:      pick = by_level(level, 5'b01101, 5'b01111);
            FK_DOMAIN:    pick = by_level(level, 5'b01001, 5'b01011);
            FK_ADDRSZ:    pick = {1'b0, SHORT_RSVD};
            FK_EXT_SYNC:  pick = {1'b1, 5'b01000};
            FK_EXT_WALK:  pick = by_level(level, 5'b01100, 5'b01110);
            FK_ASYNC_ERR: pick = {1'b1, 5'b10110};
            FK_PAR_SYNC:  pick = {1'b1, 5'b11001};
            FK_PAR_WALK:  pick = by_level(level, 5'b11100, 5'b11110);
            FK_PAR_ASYNC: pick = {1'b1, 5'b11000};
            FK_TLB_CONF:  pick = {1'b1, 5'b10000};
            FK_LOCKDOWN:  pick = {1'b1, 5'b10100};
            FK_EXCL:      pick = {1'b1, 5'b10101};
        endcase
    end

    assign ok   = pick[SHORT_W];
    assign code = pick[SHORT_W-1:0];
endmodule

// File: rtl/dfsc_long_enc.sv
module dfsc_long_enc
    import dfsc_pkg::*;
(
    input  fault_kind_e          kind,
    input  logic [LEVEL_W-1:0]   level,
    output logic [LONG_W-1:0]    code,
    output logic                 ok
);
    // level-keyed long codes: a 4-bit class prefix followed by the level
    function automatic logic [LONG_W:0] leveled(input logic [PREFIX_W-1:0] prefix,
                                                input logic [LEVEL_W-1:0]  lv,
                                                input logic                zero_ok);
        if (lv == '0 && !zero_ok) return {1'b0, LONG_RSVD};
        return {1'b1, prefix, lv};
    endfunction

    logic [LONG_W:0] pick;

    always_comb begin
        pick = {1'b0, LONG_RSVD};
        unique case (kind)
            FK_ADDRSZ:    pick = leveled(4'b0000, level, 1'b1);
            FK_XLATE:     pick = leveled(4'b0001, level, 1'b0);
            FK_AFLAG:     pick = leveled(4'b0010, level, 1'b0);
            FK_PERM:      pick = leveled(4'b0011, level, 1'b0);
            FK_EXT_WALK:  pick = leveled(4'b0101, level, 1'b0);
            FK_PAR_WALK:  pick = leveled(4'b0111, level, 1'b0);
            FK_DOMAIN:    pick = {1'b0, LONG_RSVD};
            FK_EXT_SYNC:  pick = {1'b1, 6'b010000};
            FK_ASYNC_ERR: pick = {1'b1, LONG_ASYNC};
            FK_PAR_SYNC:  pick = {1'b1, 6'b011000};
            FK_PAR_ASYNC: pick = {1'b1, 6'b011001};
            FK_ALIGN:     pick = {1'b1, 6'b100001};
            FK_DEBUG:     pick = {1'b1, 6'b100010};
            FK_TLB_CONF:  pick = {1'b1, 6'b110000};
            FK_LOCKDOWN:  pick = {1'b1, 6'b110100};
            FK_EXCL:      pick = {1'b1, 6'b110101};
        endcase
    end

    assign ok   = pick[LONG_W];
    assign code = pick[LONG_W-1:0];
endmodule

// File: rtl/dfsc_pack.sv
module dfsc_pack
    import dfsc_pkg::*;
(
    input  fault_desc_t          desc,
    input  logic [SHORT_W-1:0]   short_code,
    input  logic                 short_ok,
    input  logic [LONG_W-1:0]    long_code,
    input  logic                 long_ok,
    output logic [WORD_W-1:0]    word,
    output logic                 unsupported
);
    logic is_external;
    logic aet_live;

    always_comb begin
        unique case (desc.kind)
            FK_EXT_SYNC, FK_EXT_WALK, FK_ASYNC_ERR,
            FK_PAR_SYNC, FK_PAR_WALK, FK_PAR_ASYNC: is_external = 1'b1;
            default:                                is_external = 1'b0;
        endcase
    end

    assign aet_live = desc.layout_long && (long_code == LONG_ASYNC);

    always_comb begin
        word = '0;
        word[POS_ADDR_BAD] = (desc.kind == FK_EXT_SYNC) && desc.addr_invalid;
        word[POS_AET_LO +: AET_W] = aet_live ? desc.err_type : '0;
        word[POS_CM]     = desc.cm_origin;
        word[POS_EXT]    = is_external && desc.ext_class;
        word[POS_WNR]    = desc.wnr || desc.cm_origin;
        word[POS_LAYOUT] = desc.layout_long;
        if (desc.layout_long) begin
            word[LONG_W-1:0] = long_code;
        end else begin
            word[POS_SHORT_HI]          = short_code[SHORT_W-1];
            word[SHORT_W-2:0]           = short_code[SHORT_W-2:0];
            word[POS_DOMAIN +: DOMAIN_W] = desc.domain;
        end
        unsupported = desc.layout_long ? !long_ok : !short_ok;
    end
endmodule

// File: rtl/dfsc_capture.sv
module dfsc_capture
    import dfsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 abort_valid,
    input  logic                 layout_long,
    input  logic [KIND_W-1:0]    fault_kind,
    input  logic [LEVEL_W-1:0]   fault_level,
    input  logic                 wnr,
    input  logic                 cm_origin,
    input  logic                 ext_class,
    input  logic                 addr_invalid,
    input  logic [AET_W-1:0]     err_type,
    input  logic [DOMAIN_W-1:0]  domain,
    output logic [WORD_W-1:0]    syndrome,
    output logic                 code_unsupported,
    output logic                 syndrome_valid
);
    fault_desc_t          desc;
    logic [SHORT_W-1:0]   short_code;
    logic                 short_ok;
    logic [LONG_W-1:0]    long_code;
    logic                 long_ok;
    logic [WORD_W-1:0]    packed_word;
    logic                 packed_bad;
    cap_state_e           state_q, state_d;
    logic                 load;

    always_comb begin
        desc.kind         = fault_kind_e'(fault_kind);
        desc.level        = fault_level;
        desc.layout_long  = layout_long;
        desc.wnr          = wnr;
        desc.cm_origin    = cm_origin;
        desc.ext_class    = ext_class;
        desc.addr_invalid = addr_invalid;
        desc.err_type     = err_type;
        desc.domain       = domain;
    end

    dfsc_short_enc u_short (
        .kind  (desc.kind),
        .level (desc.level),
        .code  (short_code),
        .ok    (short_ok)
    );

    dfsc_long_enc u_long (
        .kind  (desc.kind),
        .level (desc.level),
        .code  (long_code),
        .ok    (long_ok)
    );

    dfsc_pack u_pack (
        .desc        (desc),
        .short_code  (short_code),
        .short_ok    (short_ok),
        .long_code   (long_code),
        .long_ok     (long_ok),
        .word        (packed_word),
        .unsupported (packed_bad)
    );

    // next state and load decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_EMPTY: if (abort_valid) begin   // capture_first
                state_d = ST_HELD;
                load    = 1'b1;
            end
            ST_HELD: if (abort_valid) begin    // capture_again, else hold
                load    = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syndrome         <= '0;
            code_unsupported <= 1'b0;
        end else if (load) begin
            syndrome         <= packed_word;
            code_unsupported <= packed_bad;
        end
    end

    assign syndrome_valid = (state_q == ST_HELD);
endmodule

// File: rtl/dfsc_capture_chk.sv
module dfsc_capture_chk
    import dfsc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 abort_valid,
    input logic                 layout_long,
    input logic [KIND_W-1:0]    fault_kind,
    input logic                 cm_origin,
    input logic [WORD_W-1:0]    syndrome,
    input logic                 code_unsupported,
    input logic                 syndrome_valid
);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_valid |=> $stable(syndrome) && $stable(code_unsupported));

    assert_valid_after_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |=> syndrome_valid);

    assert_layout_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |=> syndrome[POS_LAYOUT] == $past(layout_long));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        syndrome[WORD_W-1:POS_ADDR_BAD+1] == '0);

    assert_long_gaps_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        syndrome[POS_LAYOUT] |-> (syndrome[POS_SHORT_HI] == 1'b0 && syndrome[8:LONG_W] == '0));

    assert_reserved_long_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_unsupported && syndrome[POS_LAYOUT]) |-> syndrome[LONG_W-1:0] == LONG_RSVD);

    assert_reserved_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_unsupported && !syndrome[POS_LAYOUT])
            |-> {syndrome[POS_SHORT_HI], syndrome[SHORT_W-2:0]} == SHORT_RSVD);

    assert_addr_flag_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |=> (!syndrome[POS_ADDR_BAD] || $past(fault_kind) == FK_EXT_SYNC));

    assert_aet_only_async_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (syndrome[POS_AET_LO +: AET_W] != '0)
            |-> (syndrome[POS_LAYOUT] && syndrome[LONG_W-1:0] == LONG_ASYNC));

    assert_wnr_forced_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_valid && cm_origin) |=> syndrome[POS_WNR] && syndrome[POS_CM]);
endmodule

bind dfsc_capture dfsc_capture_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .abort_valid      (abort_valid),
    .layout_long      (layout_long),
    .fault_kind       (fault_kind),
    .cm_origin        (cm_origin),
    .syndrome         (syndrome),
    .code_unsupported (code_unsupported),
    .syndrome_valid   (syndrome_valid)
);

// File: tb/dfsc_capture_tb.sv
module dfsc_capture_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort_valid = 1'b0;
    logic        layout_long = 1'b0;
    logic [3:0]  fault_kind = '0;
    logic [1:0]  fault_level = '0;
    logic        wnr = 1'b0;
    logic        cm_origin = 1'b0;
    logic        ext_class = 1'b0;
    logic        addr_invalid = 1'b0;
    logic [1:0]  err_type = '0;
    logic [3:0]  domain = '0;
    logic [31:0] syndrome;
    logic        code_unsupported;
    logic        syndrome_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic        bad;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic [31:0] last_word;
    logic        last_bad;

    always #2.5 clk = ~clk;

    dfsc_capture u_dut (
        .clk(clk), .rst_n(rst_n), .abort_valid(abort_valid), .layout_long(layout_long),
        .fault_kind(fault_kind), .fault_level(fault_level), .wnr(wnr), .cm_origin(cm_origin),
        .ext_class(ext_class), .addr_invalid(addr_invalid), .err_type(err_type),
        .domain(domain), .syndrome(syndrome), .code_unsupported(code_unsupported),
        .syndrome_valid(syndrome_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // short codes from R6; bit 5 set means the pair exists
    function automatic logic [5:0] short_ref(input int k, input int lv);
        case (k)
            0:  return 6'h20 | 6'h01;
            1:  return 6'h20 | 6'h02;
            7:  return 6'h20 | 6'h08;
            9:  return 6'h20 | 6'h16;
            10: return 6'h20 | 6'h19;
            12: return 6'h20 | 6'h18;
            13: return 6'h20 | 6'h10;
            14: return 6'h20 | 6'h14;
            15: return 6'h20 | 6'h15;
            default: ;
        endcase
        if (lv == 1) case (k)
            2: return 6'h25; 3: return 6'h23; 4: return 6'h2D;
            5: return 6'h29; 8: return 6'h2C; 11: return 6'h3C;
            default: ;
        endcase
        if (lv == 2) case (k)
            2: return 6'h27; 3: return 6'h26; 4: return 6'h2F;
            5: return 6'h2B; 8: return 6'h2E; 11: return 6'h3E;
            default: ;
        endcase
        return 6'h1F;
    endfunction

    // long codes from R7; bit 6 set means the pair exists
    function automatic logic [6:0] long_ref(input int k, input int lv);
        case (k)
            0:  return 7'h40 | 7'h21;
            1:  return 7'h40 | 7'h22;
            7:  return 7'h40 | 7'h10;
            9:  return 7'h40 | 7'h11;
            10: return 7'h40 | 7'h18;
            12: return 7'h40 | 7'h19;
            13: return 7'h40 | 7'h30;
            14: return 7'h40 | 7'h34;
            15: return 7'h40 | 7'h35;
            6:  return 7'h40 | 7'(lv);
            default: ;
        endcase
        if (lv != 0) case (k)
            2:  return 7'h40 | 7'(4 + lv);
            3:  return 7'h40 | 7'(8 + lv);
            4:  return 7'h40 | 7'(12 + lv);
            8:  return 7'h40 | 7'(20 + lv);
            11: return 7'h40 | 7'(28 + lv);
            default: ;
        endcase
        return 7'h3F;
    endfunction

    function automatic exp_t model(input int k, input int lv, input bit lg, input bit w,
                                   input bit cm, input bit ex, input bit ai,
                                   input logic [1:0] et, input logic [3:0] dm);
        exp_t e;
        logic [5:0] s;
        logic [6:0] l;
        bit ext_kind;
        e.word = 32'h0;
        ext_kind = (k >= 7 && k <= 12);
        e.word[16] = (k == 7) ? ai : 1'b0;
        e.word[13] = cm;
        e.word[12] = ext_kind ? ex : 1'b0;
        e.word[11] = cm ? 1'b1 : w;
        e.word[9]  = lg;
        if (lg) begin
            l = long_ref(k, lv);
            e.word[5:0] = l[5:0];
            e.bad = !l[6];
            if (l[5:0] == 6'h11 && l[6]) e.word[15:14] = et;
        end else begin
            s = short_ref(k, lv);
            e.word[10]  = s[4];
            e.word[3:0] = s[3:0];
            e.word[7:4] = dm;
            e.bad = !s[5];
        end
        e.tag = e.bad ? "R8" : (lg ? "R7" : "R6");
        return e;
    endfunction

    task automatic capture(input int k, input int lv, input bit lg, input bit w, input bit cm,
                           input bit ex, input bit ai, input logic [1:0] et,
                           input logic [3:0] dm, input string tag);
        exp_t e;
        @(negedge clk);
        fault_kind = 4'(k); fault_level = 2'(lv); layout_long = lg; wnr = w;
        cm_origin = cm; ext_class = ex; addr_invalid = ai; err_type = et; domain = dm;
        abort_valid = 1'b1;
        e = model(k, lv, lg, w, cm, ex, ai, et, dm);
        if (tag != "") e.tag = tag;
        sb.push_back(e);
        last_word = e.word;
        last_bad = e.bad;
        @(negedge clk);
        abort_valid = 1'b0;
    endtask

    // monitor: pop one expected item per captured abort
    always @(posedge clk) begin
        if (abort_valid === 1'b1 && rst_n === 1'b1) begin
            #1;
            if (sb.size() == 0) begin
                check(1'b0, "R2 queue", 64'(syndrome), 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(syndrome === e.word && code_unsupported === e.bad, e.tag,
                      {31'h0, code_unsupported, syndrome}, {31'h0, e.bad, e.word});
                check(syndrome_valid === 1'b1, "R2 valid", 64'(syndrome_valid), 64'h1);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(syndrome === 32'h0, "R1 word", 64'(syndrome), 64'h0);
        check(code_unsupported === 1'b0 && syndrome_valid === 1'b0, "R1 flags",
              {62'h0, code_unsupported, syndrome_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(syndrome_valid === 1'b0, "R1 valid before capture", 64'(syndrome_valid), 64'h0);

        // directed examples
        capture(2, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'hA, "R4 short xlate L1");
        capture(11, 2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 4'h3, "R4 short bit10 split");
        capture(0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'hF, "R5 long align");
        capture(7, 0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 4'h0, "R9 R12 addr flag");
        capture(8, 1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 4'h0, "R9 flag masked on walk");
        capture(9, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 4'h0, "R10 aet long async");
        capture(9, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 4'h0, "R10 aet masked short");
        capture(4, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 4'h0, "R11 cm forces wnr");
        capture(4, 2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, 4'h0, "R12 ext masked");
        capture(2, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h5, "R8 short level 3");
        capture(5, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 4'h5, "R8 long domain");

        // R2 hold: inputs change while strobe stays low
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fault_kind = 4'(i * 5); layout_long = ~layout_long; domain = 4'(i);
            cm_origin = ~cm_origin; err_type = 2'(i);
        end
        @(negedge clk);
        check(syndrome === last_word && code_unsupported === last_bad, "R2 hold",
              {31'h0, code_unsupported, syndrome}, {31'h0, last_bad, last_word});
        check(syndrome[31:17] === 15'h0, "R3 upper zero", 64'(syndrome[31:17]), 64'h0);

        // sweep: every kind, level and layout with varied qualifiers (R3, R6, R7, R8)
        for (int lg = 0; lg < 2; lg++) begin
            for (int k = 0; k < 16; k++) begin
                for (int lv = 0; lv < 4; lv++) begin
                    int idx;
                    idx = k * 4 + lv + lg * 7;
                    capture(k, lv, lg[0], idx[0], idx[3] & idx[1], idx[2], idx[1],
                            2'(idx >> 1), 4'(idx * 3), "");
                end
            end
        end

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 all consumed", 64'(sb.size()), 64'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule